// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit accumulator driven by an external pulse pin. It runs in one of two modes. In event-counting mode it adds one for every pin transition of a chosen polarity. In gated-time mode it adds one on every clock cycle in which a timebase tick is high and the pin is at its enabling level. A single polarity bit chooses the counted edge in the first mode and the inhibiting level in the second.

A small register bus accesses a control byte, the counter and a sticky flag pair. The flags record a counter wrap and an active pin edge. The control byte also stores a timer-channel function select and a two-bit periodic-interrupt rate select. Both are held and exported as plain outputs for logic outside this block. The pin passes through a two-flop synchronizer before it is used.

Top module: `pulse_accum`

## Requirements
- R1: After reset, the control byte, the counter, both flags, `chan_func_sel` and `irq_rate_sel` are all zero.
- R2: The control byte is at address 0 and has this layout: bit 6 enable, bit 5 mode (0 event counting, 1 gated time), bit 4 polarity, bit 2 drives `chan_func_sel`, bits 1:0 drive `irq_rate_sel`. A write takes effect at the next clock edge.
- R3: Control bits 7 and 3 always read 0. Writing 1 to them has no effect.
- R4: While the enable bit is 0, the counter holds its value whatever the pin and tick do. The only exception is a bus write to the counter.
- R5: In event mode, polarity 0 counts falling pin edges and polarity 1 counts rising pin edges. The counter changes at the third rising clock edge after the pin changes, because of two synchronizer stages and one history stage.
- R6: In gated mode, the counter adds one on each clock edge where `base_tick` is 1 and the synchronized pin is not inhibiting. With polarity 0 a low pin inhibits counting; with polarity 1 a high pin inhibits counting. When `base_tick` is 0, nothing is counted.
- R7: A step from 0xFF to 0x00 sets the sticky overflow flag. Writing a byte with bit 0 set to address 2 clears the flag. If a wrap and that clear fall in the same cycle, the flag ends up set.
- R8: While enabled, the sticky edge flag is set by a falling pin edge under polarity 0 and by a rising pin edge under polarity 1, in both modes. In gated mode this is the edge that closes the gate. Writing a byte with bit 1 set to address 2 clears the flag, and a set in the same cycle wins.
- R9: A write to address 1 loads the counter. The load takes priority over an increment in the same cycle and never sets the overflow flag.
- R10: `bus_rdata` combinationally shows the addressed register. Address 0 returns the control byte, address 1 the counter, address 2 returns {bit 1 edge flag, bit 0 overflow flag} with the other bits zero, and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pulse_in | input | 1 | Asynchronous pulse or gate pin |
| base_tick | input | 1 | Timebase tick used in gated mode |
| count_out | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| edge_flag | output | 1 | Sticky active-edge flag |
| chan_func_sel | output | 1 | Stored timer-channel function select |
| irq_rate_sel | output | 2 | Stored periodic-interrupt rate select |

## Verification
Two pairs of events can fall in the same clock cycle here. The first is a bus write to the counter and an increment. The second is a counter wrap and a software clear of the overflow flag. The bench holds `base_tick` high in gated mode with the gate open, so the counter steps on every cycle. It then loads 0xFF and, on the very next cycle, issues the overflow clear. The result is judged against the stated priorities: the load value appears without a step, and the overflow flag stays set after the wrap. A behavioural reference model follows every cycle, so coincidences that arise unplanned during the other sequences are judged the same way.

// File: rtl/pa_pkg.sv
package pa_pkg;

  // Bus geometry
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 8;

  // Register addresses
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;

  // Control byte field positions
  localparam int unsigned BIT_EN    = 6;
  localparam int unsigned BIT_MODE  = 5;
  localparam int unsigned BIT_POL   = 4;
  localparam int unsigned BIT_CHAN  = 2;
  localparam int unsigned RATE_LSB  = 0;
  localparam int unsigned RATE_W    = 2;

  // Flag register bit positions (read and write-one-to-clear)
  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_EDGE = 1;

  typedef struct packed {
    logic              en;
    logic              gated;
    logic              pol;
    logic              chan;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] b);
    ctrl_t c;
    c.en    = b[BIT_EN];
    c.gated = b[BIT_MODE];
    c.pol   = b[BIT_POL];
    c.chan  = b[BIT_CHAN];
    c.rate  = b[RATE_LSB +: RATE_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
    logic [CTRL_W-1:0] b;
    b                     = '0;
    b[BIT_EN]             = c.en;
    b[BIT_MODE]           = c.gated;
    b[BIT_POL]            = c.pol;
    b[BIT_CHAN]           = c.chan;
    b[RATE_LSB +: RATE_W] = c.rate;
    return b;
  endfunction

endpackage

// File: rtl/pa_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module pa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pa_sync.sv
// Pin synchronizer followed by one history stage for edge detection.
module pa_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic prev
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign level = pipe_q[STAGES-1];
  assign prev  = pipe_q[STAGES];

endmodule

// File: rtl/pa_core.sv
// Edge / gate qualification and the counter itself.
module pa_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             prev,
  input  logic             tick,
  input  logic             en,
  input  logic             gated,
  input  logic             pol,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             edge_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             rise, fall, sel_edge, gate_open, step;
  logic [CNT_W-1:0] count_q, count_d;

  // Edge and gate decode. The polarity bit picks the counted edge in
  // event mode and the inhibiting level in gated mode; the edge that
  // closes the gate coincides with the counted edge of event mode.
  always_comb begin
    rise      = level & ~prev;
    fall      = ~level & prev;
    sel_edge  = pol ? rise : fall;
    gate_open = pol ? ~level : level;
    if (gated) begin
      step = en & tick & gate_open;
    end else begin
      step = en & sel_edge;
    end
    edge_hit = en & sel_edge;
  end

  // Next-state: bus load has priority over a step.
  always_comb begin
    wrap = 1'b0;
    if (load_en) begin
      count_d = load_val;
    end else if (step) begin
      count_d = count_q + 1'b1;
      wrap    = (count_q == CNT_MAX);
    end else begin
      count_d = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/pa_regs.sv
// Control byte, sticky flags and the read multiplexer.
module pa_regs
  import pa_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  input  logic              edge_hit,
  output ctrl_t             ctrl,
  output logic              ovf,
  output logic              edge_seen,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_val
);

  logic  wr, wr_ctrl, wr_flags;
  logic  clr_ovf, clr_edge;
  ctrl_t ctrl_q, ctrl_d;
  logic  ovf_q, ovf_d, edge_q, edge_d;

  always_comb begin
    wr       = bus_sel & bus_we;
    wr_ctrl  = wr & (bus_addr == A_CTRL);
    wr_flags = wr & (bus_addr == A_FLAGS);
    load_en  = wr & (bus_addr == A_COUNT);
    load_val = bus_wdata;
    clr_ovf  = wr_flags & bus_wdata[FLAG_OVF];
    clr_edge = wr_flags & bus_wdata[FLAG_EDGE];
  end

  // Next-state: a flag set wins over a clear in the same cycle.
  always_comb begin
    ctrl_d = wr_ctrl ? unpack_ctrl(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    ovf_d  = wrap     | (ovf_q  & ~clr_ovf);
    edge_d = edge_hit | (edge_q & ~clr_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovf_q  <= ovf_d;
      edge_q <= edge_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = CNT_W'(pack_ctrl(ctrl_q));
      A_COUNT: bus_rdata = count;
      A_FLAGS: begin
        bus_rdata[FLAG_OVF]  = ovf_q;
        bus_rdata[FLAG_EDGE] = edge_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign ovf       = ovf_q;
  assign edge_seen = edge_q;

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              pulse_in,
  input  logic              base_tick,
  output logic [CNT_W-1:0]  count_out,
  output logic              ovf_flag,
  output logic              edge_flag,
  output logic              chan_func_sel,
  output logic [RATE_W-1:0] irq_rate_sel
);

  logic             rst_n_int;
  logic             pin_level, pin_prev;
  ctrl_t            ctrl_s;
  logic             load_en;
  logic [CNT_W-1:0] load_val, count_s;
  logic             wrap_s, edge_hit_s;

  pa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .din  (pulse_in),
    .level(pin_level),
    .prev (pin_prev)
  );

  pa_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count    (count_s),
    .wrap     (wrap_s),
    .edge_hit (edge_hit_s),
    .ctrl     (ctrl_s),
    .ovf      (ovf_flag),
    .edge_seen(edge_flag),
    .load_en  (load_en),
    .load_val (load_val)
  );

  pa_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .level   (pin_level),
    .prev    (pin_prev),
    .tick    (base_tick),
    .en      (ctrl_s.en),
    .gated   (ctrl_s.gated),
    .pol     (ctrl_s.pol),
    .load_en (load_en),
    .load_val(load_val),
    .count   (count_s),
    .wrap    (wrap_s),
    .edge_hit(edge_hit_s)
  );

  assign count_out     = count_s;
  assign chan_func_sel = ctrl_s.chan;
  assign irq_rate_sel  = ctrl_s.rate;

endmodule

// File: rtl/pa_checker.sv
module pa_checker
  import pa_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  bus_rdata,
  input logic              base_tick,
  input logic [CNT_W-1:0]  count_out,
  input logic              ovf_flag,
  input logic              edge_flag,
  input logic              acc_en,
  input logic              acc_gated
);

  logic cnt_wr, flg_wr;
  assign cnt_wr = bus_sel && bus_we && (bus_addr == A_COUNT);
  assign flg_wr = bus_sel && bus_we && (bus_addr == A_FLAGS);

  a_r3_unimpl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0));

  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !cnt_wr) |=> $stable(count_out));

  a_r5_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (CNT_W'(count_out - $past(count_out)) <= CNT_W'(1)));

  a_r6_no_tick_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_gated && !base_tick && !cnt_wr) |=> $stable(count_out));

  a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count_out == {CNT_W{1'b1}}) |=> (count_out == {CNT_W{1'b1}} || ovf_flag));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flg_wr && bus_wdata[FLAG_OVF])) |=> ovf_flag);

  a_r8_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !(flg_wr && bus_wdata[FLAG_EDGE])) |=> edge_flag);

  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_out == $past(bus_wdata)));

endmodule

bind pulse_accum pa_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .base_tick(base_tick),
  .count_out(count_out),
  .ovf_flag (ovf_flag),
  .edge_flag(edge_flag),
  .acc_en   (ctrl_s.en),
  .acc_gated(ctrl_s.gated)
);

// File: tb/pulse_accum_test.sv
`timescale 1ns/1ps
module pulse_accum_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk, rst_n;
  logic       bus_sel, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       pulse_in, base_tick;
  logic [7:0] count_out;
  logic       ovf_flag, edge_flag, chan_func_sel;
  logic [1:0] irq_rate_sel;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  pulse_accum uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pulse_in(pulse_in), .base_tick(base_tick), .count_out(count_out),
    .ovf_flag(ovf_flag), .edge_flag(edge_flag),
    .chan_func_sel(chan_func_sel), .irq_rate_sel(irq_rate_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, updated once per rising edge.
  logic [7:0] m_cnt, m_ctrl;
  bit         m_ovf, m_edge;
  bit         h0, h1, h2;   // pin samples 1, 2 and 3 clocks old

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_ovf = 0; m_edge = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      bit wr, en, gated, pol, hit, inc, wrapped;
      wr      = bus_sel && bus_we;
      en      = m_ctrl[6]; gated = m_ctrl[5]; pol = m_ctrl[4];
      hit     = pol ? (h1 && !h2) : (!h1 && h2);
      inc     = en && (gated ? (base_tick && (pol ? !h1 : h1)) : hit);
      wrapped = 0;
      if (wr && bus_addr == 2'd1) m_cnt = bus_wdata;
      else if (inc) begin
        wrapped = (m_cnt == 8'hFF);
        m_cnt   = m_cnt + 8'd1;
      end
      if (wrapped) m_ovf = 1;
      else if (wr && bus_addr == 2'd2 && bus_wdata[0]) m_ovf = 0;
      if (en && hit) m_edge = 1;
      else if (wr && bus_addr == 2'd2 && bus_wdata[1]) m_edge = 0;
      if (wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 8'h77;
      h2 = h1; h1 = h0; h0 = pulse_in;
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_cnt;
      2'd2: return {6'd0, m_edge, m_ovf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    check(phase, "model count", count_out, m_cnt);
    check(phase, "model ovf", {7'd0, ovf_flag}, {7'd0, m_ovf});
    check(phase, "model edge", {7'd0, edge_flag}, {7'd0, m_edge});
    check(phase, "model chan", {7'd0, chan_func_sel}, {7'd0, m_ctrl[2]});
    check(phase, "model rate", {6'd0, irq_rate_sel}, {6'd0, m_ctrl[1:0]});
    check(phase, "model rdata", bus_rdata, m_read(bus_addr));
  end

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic read_check(input string req, input logic [1:0] a,
                            input logic [7:0] exp);
    bus_addr = a; bus_sel = 1; #1;
    check(req, "bus read", bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = ~pulse_in; step(4);
      pulse_in = ~pulse_in; step(4);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    pulse_in = 0; base_tick = 0;
    #1 rst_n = 0;
    step(3);
    rst_n = 1;
    step(4);

    phase = "R1";
    check("R1", "count", count_out, 8'h00);
    check("R1", "ovf", {7'd0, ovf_flag}, 8'h00);
    check("R1", "edge", {7'd0, edge_flag}, 8'h00);
    check("R1", "rate", {6'd0, irq_rate_sel}, 8'h00);
    read_check("R1", 2'd0, 8'h00);

    phase = "R2";
    bus_write(2'd0, 8'hFF);
    read_check("R3", 2'd0, 8'h77);
    check("R2", "chan", {7'd0, chan_func_sel}, 8'h01);
    check("R2", "rate", {6'd0, irq_rate_sel}, 8'h03);
    phase = "R3";
    bus_write(2'd0, 8'h88);
    read_check("R3", 2'd0, 8'h00);

    phase = "R4";
    bus_write(2'd0, 8'h10);
    base_tick = 1;
    pulses(3);
    base_tick = 0;
    check("R4", "count held", count_out, 8'h00);
    check("R4", "no edge flag", {7'd0, edge_flag}, 8'h00);

    phase = "R5";
    bus_write(2'd0, 8'h40);
    pulse_in = 1; step(4);
    check("R5", "rising ignored pol0", count_out, 8'h00);
    pulse_in = 0; step(2);
    check("R5", "latency not yet", count_out, 8'h00);
    step(1);
    check("R5", "falling counted at third edge", count_out, 8'h01);
    pulses(2);
    check("R5", "three falls", count_out, 8'h03);
    check("R8", "edge flag set", {7'd0, edge_flag}, 8'h01);
    bus_write(2'd2, 8'h02);
    check("R8", "edge flag cleared", {7'd0, edge_flag}, 8'h00);
    bus_write(2'd0, 8'h50);
    pulses(2);
    check("R5", "rising pol1", count_out, 8'h05);

    phase = "R9";
    bus_write(2'd1, 8'h00);
    read_check("R10", 2'd1, 8'h00);

    phase = "R6";
    bus_write(2'd0, 8'h60);
    pulse_in = 1; step(4);
    bus_write(2'd2, 8'h02);
    base_tick = 1; step(5); base_tick = 0; step(1);
    check("R6", "gate open high", count_out, 8'h05);
    pulse_in = 0; step(4);
    check("R8", "gate-closing edge", {7'd0, edge_flag}, 8'h01);
    base_tick = 1; step(6); base_tick = 0; step(1);
    check("R6", "low inhibits pol0", count_out, 8'h05);
    bus_write(2'd0, 8'h70);
    base_tick = 1; step(3); base_tick = 0; step(1);
    check("R6", "low counts pol1", count_out, 8'h08);
    for (int i = 0; i < 4; i++) begin
      base_tick = ~base_tick; step(1);
    end
    base_tick = 0; step(1);
    check("R6", "alternating tick", count_out, 8'h0A);

    phase = "R7";
    bus_write(2'd0, 8'h60);
    pulse_in = 1; step(4);
    bus_write(2'd1, 8'hFE);
    base_tick = 1; step(2); base_tick = 0; step(1);
    check("R7", "wrapped count", count_out, 8'h00);
    check("R7", "ovf set", {7'd0, ovf_flag}, 8'h01);
    bus_write(2'd2, 8'h01);
    check("R7", "ovf cleared", {7'd0, ovf_flag}, 8'h00);
    base_tick = 1;
    bus_write(2'd1, 8'hFF);
    check("R9", "load beats step", count_out, 8'hFF);
    bus_write(2'd2, 8'h01);
    base_tick = 0;
    check("R7", "wrap with clear keeps ovf", {7'd0, ovf_flag}, 8'h01);
    check("R7", "count after wrap", count_out, 8'h00);

    phase = "R9";
    base_tick = 1;
    bus_write(2'd1, 8'h10);
    base_tick = 0;
    check("R9", "load priority", count_out, 8'h10);
    check("R9", "load no ovf change", {7'd0, ovf_flag}, 8'h01);

    phase = "R10";
    bus_write(2'd2, 8'h03);
    read_check("R10", 2'd2, 8'h00);
    read_check("R10", 2'd3, 8'h00);
    pulse_in = 0; step(4);
    read_check("R10", 2'd2, 8'h02);

    step(3);
    finish_up();
  end

endmodule